// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the state changes a processor makes when it takes a trap. A request arrives with a 9-bit trap type, the current program counter and next program counter, a saved-state word, the current register window pointer with its count of savable windows, and the trap base address. In one clock edge the block raises the trap level and stores the interrupted context in a per-level trap stack. It also picks the new privilege and global-register mode from the trap type, moves the window pointer for window-management traps, and forms the handler fetch address with its successor.

The trap level starts at zero after reset. When the last usable level is taken, a sticky red-state flag is raised. A request that arrives with the level already at the ceiling sets a sticky error flag and changes nothing else. From then on the block ignores requests until reset. A combinational read port gives the contents of any stack level so that the saved context can be restored later.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the trap level, the red flag, the error flag, the done strobe, the handler PC, the next PC, the window output and the mode output are all zero, and every stack entry reads as zero.
- R2: A request made while the trap level equals MAX_TL (default 6) sets the error flag and produces no done strobe. The level, PC and other outputs keep their values. Once the error flag is set it stays set, and requests have no effect until reset.
- R3: An accepted request raises the trap level by exactly one. When the level before the request is MAX_TL-1, the request also sets the red flag, which stays set until reset.
- R4: An accepted request stores the saved-state word, PC, next PC and trap type in the stack entry of the new level. Selecting level L (1..MAX_TL) on the read port returns that entry. Entries of other levels are unchanged.
- R5: The handler PC is the trap base with bits 14:0 cleared, OR bit 14 set when the new level exceeds 1, OR the trap type shifted left by 5.
- R6: The next PC output equals the handler PC plus 4.
- R7: The mode output has the layout bit0 privileged, bit1 FPU enable, bit2 alternate globals, bit3 MMU globals and bit4 interrupt globals. Trap types 0x008, 0x030 and 0x064 through 0x06F give 5'b01011.
- R8: Trap type 0x060 gives mode 5'b10011. Every other type not listed in R7 gives 5'b00111.
- R9: Trap type 0x024 sets the window output to the window input minus 1, modulo NWIN (default 8).
- R10: Trap types with bits 8:6 equal to 3'b010 (0x080..0x0BF) set the window output to window input minus save count minus 2, modulo NWIN. The save count must be below NWIN.
- R11: Trap types with bits 8:6 equal to 3'b011 (0x0C0..0x0FF) set the window output to the window input plus 1, modulo NWIN. Any other trap type copies the window input unchanged.
- R12: Each accepted request produces a done strobe that is high for exactly the one cycle after the request edge. All result outputs are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Trap request, sampled each edge |
| ttype_i | input | 9 | Trap type |
| pc_i | input | AW | PC of the interrupted instruction |
| npc_i | input | AW | Next PC of the interrupted instruction |
| tstate_i | input | TS_W | Saved-state word to push |
| cwp_i | input | CW | Current window pointer |
| cansave_i | input | CW | Count of savable windows |
| tba_i | input | AW | Trap base address |
| rd_lvl_i | input | TL_W | Stack level to read |
| pc_o | output | AW | Handler PC |
| npc_o | output | AW | Handler next PC |
| tl_o | output | TL_W | Current trap level |
| cwp_o | output | CW | Window pointer after the trap |
| mode_o | output | 5 | Processor mode bits after the trap |
| red_o | output | 1 | Red-state flag |
| err_o | output | 1 | Error flag |
| done_o | output | 1 | Trap entry complete strobe |
| rd_tstate_o | output | TS_W | Saved state at the selected level |
| rd_tpc_o | output | AW | Saved PC at the selected level |
| rd_tnpc_o | output | AW | Saved next PC at the selected level |
| rd_tt_o | output | 9 | Saved trap type at the selected level |

## Verification
The bench drives the trap level through every step up to the ceiling. A design that raised the red flag one level early or late, or that pushed to the old level instead of the new one, would show a wrong flag or a misplaced stack entry. The bench then sends two requests at the ceiling and checks that neither produces a done strobe or moves the level or the PC. A design that still incremented past the ceiling or let the error clear would fail there. Window traps are chosen so that the result wraps below zero (clean, spill with a large save count) and above the top (fill from window 7). Mode and nested-vector-bit cases cover the MMU range edges, the vector interrupt and a plain type, so a wrong bit in the class decode or in the nesting test changes the expected PC or mode.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

   typedef enum logic [1:0] {
      WIN_KEEP  = 2'd0,
      WIN_CLEAN = 2'd1,
      WIN_SPILL = 2'd2,
      WIN_FILL  = 2'd3
   } win_op_e;

   typedef struct packed {
      logic intr_glob;
      logic mmu_glob;
      logic alt_glob;
      logic fpu_en;
      logic priv;
   } mode_t;

   localparam int TT_W   = 9;
   localparam int MODE_W = 5;

   localparam logic [TT_W-1:0] TY_CLEAN    = 9'h024;
   localparam logic [TT_W-1:0] TY_VECINT   = 9'h060;
   localparam logic [TT_W-1:0] TY_IFAULT   = 9'h008;
   localparam logic [TT_W-1:0] TY_DFAULT   = 9'h030;
   localparam logic [TT_W-1:0] TY_XLATE_LO = 9'h064;
   localparam logic [TT_W-1:0] TY_XLATE_HI = 9'h06F;
   localparam logic [2:0]      GRP_SPILL   = 3'b010;
   localparam logic [2:0]      GRP_FILL    = 3'b011;

   localparam int VEC_ALIGN = 15;
   localparam int NEST_BIT  = 14;
   localparam int TT_SHIFT  = 5;

endpackage

// File: rtl/trap_class_dec.sv
module trap_class_dec
   import trap_seq_pkg::*;
(
   input  logic [TT_W-1:0] ttype_i,
   output mode_t           mode_o,
   output win_op_e         win_op_o
);

   logic is_mmu;
   logic is_vec;

   always_comb begin
      is_mmu = (ttype_i == TY_IFAULT) || (ttype_i == TY_DFAULT) ||
               ((ttype_i >= TY_XLATE_LO) && (ttype_i <= TY_XLATE_HI));
      is_vec = (ttype_i == TY_VECINT);

      mode_o           = '0;
      mode_o.priv      = 1'b1;
      mode_o.fpu_en    = 1'b1;
      mode_o.mmu_glob  = is_mmu;
      mode_o.intr_glob = is_vec;
      mode_o.alt_glob  = !is_mmu && !is_vec;
   end

   always_comb begin
      if (ttype_i == TY_CLEAN)
         win_op_o = WIN_CLEAN;
      else if (ttype_i[8:6] == GRP_SPILL)
         win_op_o = WIN_SPILL;
      else if (ttype_i[8:6] == GRP_FILL)
         win_op_o = WIN_FILL;
      else
         win_op_o = WIN_KEEP;
   end

endmodule

// File: rtl/trap_win_adj.sv
module trap_win_adj
   import trap_seq_pkg::*;
#(
   parameter int NWIN = 8,
   localparam int CW  = $clog2(NWIN)
) (
   input  win_op_e         op_i,
   input  logic [CW-1:0]   cwp_i,
   input  logic [CW-1:0]   cansave_i,
   output logic [CW-1:0]   cwp_o
);

   localparam int EW = CW + 2;
   localparam logic [EW-1:0] N_E  = EW'(NWIN);
   localparam logic [EW-1:0] N2_E = EW'(2 * NWIN);
   localparam bit POW2 = ((1 << CW) == NWIN);

   logic [EW-1:0] cw_e;
   logic [EW-1:0] cs_e;
   logic [EW-1:0] raw;

   always_comb begin
      cw_e = EW'(cwp_i);
      cs_e = EW'(cansave_i);
      unique case (op_i)
         WIN_CLEAN: raw = cw_e + N_E - EW'(1);
         WIN_SPILL: raw = cw_e + N2_E - cs_e - EW'(2);
         WIN_FILL:  raw = cw_e + EW'(1);
         default:   raw = cw_e;
      endcase
   end

   generate
      if (POW2) begin : g_mask
         assign cwp_o = raw[CW-1:0];
      end else begin : g_mod
         logic [EW-1:0] rem;
         assign rem   = raw % N_E;
         assign cwp_o = rem[CW-1:0];
      end
   endgenerate

endmodule

// File: rtl/trap_stack.sv
module trap_stack
   import trap_seq_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int AW    = 64,
   parameter int TS_W  = 32,
   parameter int TL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [TL_W-1:0]   wlvl_i,
   input  logic [TS_W-1:0]   tstate_i,
   input  logic [AW-1:0]     tpc_i,
   input  logic [AW-1:0]     tnpc_i,
   input  logic [TT_W-1:0]   tt_i,
   input  logic [TL_W-1:0]   rlvl_i,
   output logic [TS_W-1:0]   tstate_o,
   output logic [AW-1:0]     tpc_o,
   output logic [AW-1:0]     tnpc_o,
   output logic [TT_W-1:0]   tt_o
);

   logic [TS_W-1:0] st_q  [DEPTH];
   logic [AW-1:0]   pc_q  [DEPTH];
   logic [AW-1:0]   npc_q [DEPTH];
   logic [TT_W-1:0] tt_q  [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         localparam logic [TL_W-1:0] LVL = TL_W'(g + 1);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_q[g]  <= '0;
               pc_q[g]  <= '0;
               npc_q[g] <= '0;
               tt_q[g]  <= '0;
            end else if (we_i && (wlvl_i == LVL)) begin
               st_q[g]  <= tstate_i;
               pc_q[g]  <= tpc_i;
               npc_q[g] <= tnpc_i;
               tt_q[g]  <= tt_i;
            end
         end
      end
   endgenerate

   always_comb begin
      tstate_o = '0;
      tpc_o    = '0;
      tnpc_o   = '0;
      tt_o     = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rlvl_i == TL_W'(i + 1)) begin
            tstate_o = st_q[i];
            tpc_o    = pc_q[i];
            tnpc_o   = npc_q[i];
            tt_o     = tt_q[i];
         end
      end
   end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_seq_pkg::*;
#(
   parameter int AW     = 64,
   parameter int TS_W   = 32,
   parameter int NWIN   = 8,
   parameter int MAX_TL = 6,
   localparam int TL_W  = $clog2(MAX_TL + 1),
   localparam int CW    = $clog2(NWIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [8:0]        ttype_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [AW-1:0]     npc_i,
   input  logic [TS_W-1:0]   tstate_i,
   input  logic [CW-1:0]     cwp_i,
   input  logic [CW-1:0]     cansave_i,
   input  logic [AW-1:0]     tba_i,
   input  logic [TL_W-1:0]   rd_lvl_i,
   output logic [AW-1:0]     pc_o,
   output logic [AW-1:0]     npc_o,
   output logic [TL_W-1:0]   tl_o,
   output logic [CW-1:0]     cwp_o,
   output logic [4:0]        mode_o,
   output logic              red_o,
   output logic              err_o,
   output logic              done_o,
   output logic [TS_W-1:0]   rd_tstate_o,
   output logic [AW-1:0]     rd_tpc_o,
   output logic [AW-1:0]     rd_tnpc_o,
   output logic [8:0]        rd_tt_o
);

   localparam logic [TL_W-1:0] TL_TOP  = TL_W'(MAX_TL);
   localparam logic [TL_W-1:0] TL_LAST = TL_W'(MAX_TL - 1);
   localparam logic [AW-1:0]   STEP    = AW'(4);

   generate
      if (NWIN < 2) begin : g_bad_nwin
         $error("NWIN must be at least 2");
      end
      if (MAX_TL < 2) begin : g_bad_tl
         $error("MAX_TL must be at least 2");
      end
      if (AW < VEC_ALIGN + 1) begin : g_bad_aw
         $error("AW too narrow for the vector layout");
      end
   endgenerate

   logic [TL_W-1:0] tl_q;
   logic            red_q;
   logic            err_q;
   logic            done_q;
   logic [AW-1:0]   pc_q;
   logic [AW-1:0]   npc_q;
   logic [CW-1:0]   cwp_q;
   mode_t           mode_q;

   mode_t           mode_d;
   win_op_e         win_op;
   logic [CW-1:0]   cwp_d;
   logic [TL_W-1:0] tl_d;
   logic            accept;
   logic            fault;
   logic            nested;
   logic [AW-1:0]   vec;

   trap_class_dec u_dec (
      .ttype_i  (ttype_i),
      .mode_o   (mode_d),
      .win_op_o (win_op)
   );

   trap_win_adj #(.NWIN(NWIN)) u_win (
      .op_i      (win_op),
      .cwp_i     (cwp_i),
      .cansave_i (cansave_i),
      .cwp_o     (cwp_d)
   );

   always_comb begin
      accept = req_i && !err_q && (tl_q < TL_TOP);
      fault  = req_i && !err_q && (tl_q >= TL_TOP);
      tl_d   = tl_q + TL_W'(1);
      nested = (tl_d > TL_W'(1));
      vec    = {tba_i[AW-1:VEC_ALIGN], nested, ttype_i, {TT_SHIFT{1'b0}}};
   end

   trap_stack #(
      .DEPTH (MAX_TL),
      .AW    (AW),
      .TS_W  (TS_W),
      .TL_W  (TL_W)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (accept),
      .wlvl_i   (tl_d),
      .tstate_i (tstate_i),
      .tpc_i    (pc_i),
      .tnpc_i   (npc_i),
      .tt_i     (ttype_i),
      .rlvl_i   (rd_lvl_i),
      .tstate_o (rd_tstate_o),
      .tpc_o    (rd_tpc_o),
      .tnpc_o   (rd_tnpc_o),
      .tt_o     (rd_tt_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tl_q   <= '0;
         red_q  <= 1'b0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
         pc_q   <= '0;
         npc_q  <= '0;
         cwp_q  <= '0;
         mode_q <= '0;
      end else begin
         done_q <= accept;
         if (fault)
            err_q <= 1'b1;
         if (accept) begin
            tl_q   <= tl_d;
            if (tl_q == TL_LAST)
               red_q <= 1'b1;
            pc_q   <= vec;
            npc_q  <= vec + STEP;
            cwp_q  <= cwp_d;
            mode_q <= mode_d;
         end
      end
   end

   assign pc_o   = pc_q;
   assign npc_o  = npc_q;
   assign tl_o   = tl_q;
   assign cwp_o  = cwp_q;
   assign mode_o = mode_q;
   assign red_o  = red_q;
   assign err_o  = err_q;
   assign done_o = done_q;

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
   parameter int AW     = 64,
   parameter int MAX_TL = 6,
   parameter int TL_W   = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_i,
   input logic [TL_W-1:0] tl_o,
   input logic            red_o,
   input logic            err_o,
   input logic            done_o,
   input logic [AW-1:0]   pc_o,
   input logic [AW-1:0]   npc_o,
   input logic [4:0]      mode_o
);

   p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o && !done_o && $stable(tl_o) && $stable(pc_o));

   p_fault_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !err_o && tl_o == TL_W'(MAX_TL)) |=> err_o && !done_o);

   p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !err_o && tl_o < TL_W'(MAX_TL)) |=>
         done_o && (tl_o == $past(tl_o) + TL_W'(1)));

   p_red_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(red_o) |-> tl_o == TL_W'(MAX_TL));

   p_nest_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> pc_o[14] == (tl_o > TL_W'(1)));

   p_next_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> npc_o == pc_o + AW'(4));

   p_mode_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones(mode_o[4:2]) == 1) && (mode_o[1:0] == 2'b11));

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !done_o);

endmodule

bind trap_entry_seq trap_seq_chk #(
   .AW     (AW),
   .MAX_TL (MAX_TL),
   .TL_W   (TL_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .req_i  (req_i),
   .tl_o   (tl_o),
   .red_o  (red_o),
   .err_o  (err_o),
   .done_o (done_o),
   .pc_o   (pc_o),
   .npc_o  (npc_o),
   .mode_o (mode_o)
);

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 64;
   localparam int TS_W = 32;
   localparam int NWIN = 8;
   localparam int MAX_TL = 6;
   localparam int TL_W = 3;
   localparam int CW = 3;
   localparam logic [AW-1:0] TBA = 64'hFFFF_0000_0012_3456;

   typedef struct {
      int              tl;
      bit              red;
      logic [AW-1:0]   pc;
      logic [AW-1:0]   npc;
      int              cwp;
      logic [4:0]      mode;
      logic [8:0]      tt;
      logic [TS_W-1:0] ts;
      logic [AW-1:0]   tpc;
      logic [AW-1:0]   tnpc;
   } item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_i = 1'b0;
   logic [8:0]      ttype_i = '0;
   logic [AW-1:0]   pc_i = '0;
   logic [AW-1:0]   npc_i = '0;
   logic [TS_W-1:0] tstate_i = '0;
   logic [CW-1:0]   cwp_i = '0;
   logic [CW-1:0]   cansave_i = '0;
   logic [AW-1:0]   tba_i = TBA;
   logic [TL_W-1:0] rd_lvl_i = '0;
   logic [AW-1:0]   pc_o, npc_o, rd_tpc_o, rd_tnpc_o;
   logic [TL_W-1:0] tl_o;
   logic [CW-1:0]   cwp_o;
   logic [4:0]      mode_o;
   logic            red_o, err_o, done_o;
   logic [TS_W-1:0] rd_tstate_o;
   logic [8:0]      rd_tt_o;

   int n_chk = 0;
   int n_fail = 0;
   int m_tl = 0;
   bit m_red = 0;
   bit m_err = 0;
   int n_trap = 0;
   item_t exp_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   trap_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ttype_i(ttype_i),
      .pc_i(pc_i), .npc_i(npc_i), .tstate_i(tstate_i), .cwp_i(cwp_i),
      .cansave_i(cansave_i), .tba_i(tba_i), .rd_lvl_i(rd_lvl_i),
      .pc_o(pc_o), .npc_o(npc_o), .tl_o(tl_o), .cwp_o(cwp_o),
      .mode_o(mode_o), .red_o(red_o), .err_o(err_o), .done_o(done_o),
      .rd_tstate_o(rd_tstate_o), .rd_tpc_o(rd_tpc_o),
      .rd_tnpc_o(rd_tnpc_o), .rd_tt_o(rd_tt_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_mode(input logic [8:0] tt);
      bit mmu = (tt == 9'h008) || (tt == 9'h030) || (tt >= 9'h064 && tt <= 9'h06F);
      bit vec = (tt == 9'h060);
      return {vec, mmu, !mmu && !vec, 1'b1, 1'b1};
   endfunction

   function automatic int exp_cwp(input logic [8:0] tt, input int cw, input int cs);
      int r;
      if (tt == 9'h024)            r = cw - 1;
      else if (tt[8:6] == 3'b010)  r = cw - cs - 2;
      else if (tt[8:6] == 3'b011)  r = cw + 1;
      else                         r = cw;
      return ((r % NWIN) + NWIN) % NWIN;
   endfunction

   task automatic trap(input logic [8:0] tt, input int cw, input int cs);
      item_t e;
      n_trap++;
      if (!m_err && m_tl >= MAX_TL) begin
         m_err = 1;
      end else if (!m_err) begin
         if (m_tl == MAX_TL - 1) m_red = 1;
         m_tl++;
         e.tl   = m_tl;
         e.red  = m_red;
         e.pc   = (TBA & ~64'h7FFF) | ((m_tl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
         e.npc  = e.pc + 64'd4;
         e.cwp  = exp_cwp(tt, cw, cs);
         e.mode = exp_mode(tt);
         e.tt   = tt;
         e.ts   = 32'hA500_0000 | 32'(tt);
         e.tpc  = 64'h4000_1000 + 64'(n_trap * 16);
         e.tnpc = e.tpc + 64'd4;
         exp_q.push_back(e);
      end
      @(negedge clk);
      req_i     = 1'b1;
      ttype_i   = tt;
      cwp_i     = CW'(cw);
      cansave_i = CW'(cs);
      tstate_i  = 32'hA500_0000 | 32'(tt);
      pc_i      = 64'h4000_1000 + 64'(n_trap * 16);
      npc_i     = pc_i + 64'd4;
      @(negedge clk);
      req_i = 1'b0;
      @(negedge clk);
      chk("R12", "done single cycle", 64'(done_o), 64'd0);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 unexpected done: actual 1 expected 0");
         end else begin
            item_t e;
            e = exp_q.pop_front();
            chk("R3",  "tl",   64'(tl_o), 64'(e.tl));
            chk("R3",  "red",  64'(red_o), 64'(e.red));
            chk("R5",  "pc",   pc_o, e.pc);
            chk("R6",  "npc",  npc_o, e.npc);
            chk("R9",  "cwp",  64'(cwp_o), 64'(e.cwp));
            chk("R7",  "mode", 64'(mode_o), 64'(e.mode));
            rd_lvl_i = TL_W'(e.tl);
            #1;
            chk("R4", "stk tt",   64'(rd_tt_o), 64'(e.tt));
            chk("R4", "stk st",   64'(rd_tstate_o), 64'(e.ts));
            chk("R4", "stk pc",   rd_tpc_o, e.tpc);
            chk("R4", "stk npc",  rd_tnpc_o, e.tnpc);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [AW-1:0] last_pc;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "tl",   64'(tl_o), 0);
      chk("R1", "red",  64'(red_o), 0);
      chk("R1", "err",  64'(err_o), 0);
      chk("R1", "done", 64'(done_o), 0);
      chk("R1", "pc",   pc_o, 0);
      chk("R1", "mode", 64'(mode_o), 0);
      rd_lvl_i = 3'd1; #1;
      chk("R1", "stack empty", rd_tpc_o, 0);
      rst_n = 1'b1;

      trap(9'h024, 0, 0);   // R9 clean wraps 0 -> 7, R8 alternate, level 1 not nested
      trap(9'h068, 3, 1);   // R7 MMU class, window kept (R11), nested bit (R5)
      trap(9'h060, 5, 2);   // R8 vector interrupt
      trap(9'h085, 1, 4);   // R10 spill wraps to 3
      trap(9'h0C3, 7, 0);   // R11 fill wraps 7 -> 0
      trap(9'h06F, 2, 0);   // R7 top of MMU range, R3 red at last level
      chk("R3", "red after last level", 64'(red_o), 1);
      chk("R3", "tl at ceiling", 64'(tl_o), MAX_TL);

      rd_lvl_i = 3'd1; #1;
      chk("R4", "level1 kept", 64'(rd_tt_o), 64'h024);
      rd_lvl_i = 3'd4; #1;
      chk("R4", "level4 kept", 64'(rd_tt_o), 64'h085);

      last_pc = pc_o;
      trap(9'h030, 4, 0);   // R2 fault at ceiling
      chk("R2", "err set", 64'(err_o), 1);
      chk("R2", "tl held", 64'(tl_o), MAX_TL);
      chk("R2", "pc held", pc_o, last_pc);
      rd_lvl_i = 3'd6; #1;
      chk("R2", "stack top untouched", 64'(rd_tt_o), 64'h06F);
      trap(9'h024, 4, 0);   // R2 ignored while in error
      chk("R2", "err sticky", 64'(err_o), 1);
      chk("R2", "cwp held", 64'(cwp_o), 64'(exp_cwp(9'h06F, 2, 0)));
      chk("R2", "no stray item", 64'(exp_q.size()), 0);

      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "err cleared", 64'(err_o), 0);
      chk("R1", "red cleared", 64'(red_o), 0);
      chk("R1", "tl cleared", 64'(tl_o), 0);
      rst_n = 1'b1;
      m_tl = 0; m_red = 0; m_err = 0;
      trap(9'h100, 6, 0);   // R8 plain type, R11 window copied
      trap(9'h063, 6, 0);   // R7 just below MMU range
      chk("R2", "no error after reset", 64'(err_o), 0);
      chk("R12", "queue drained", 64'(exp_q.size()), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule